// File: doc/BRIEF.md
# Low-Power Run Entry Sequencer

This block walks a system from normal run into low-power run and back under hardware control. When entry is requested and the operating conditions allow it, it raises the flash read wait states and switches off the PLL. It then puts the flash into low-voltage mode and waits for the flash to confirm. Next it drops the wait states to zero, puts the SRAM into low-voltage mode, forces the bandgap and the supply monitors on, and hands the core supply from the main regulator to the low-power regulator. The low-power-run status flag rises only when the low-power regulator reports that it has taken over.

Clearing the request runs the same path backwards. Every acknowledge wait is bounded by a programmable cycle limit. A wait that runs out unwinds whatever has been applied so far, in reverse order, and raises an error flag. Entry starts on a rising request, or on a wake from low-power sleep while the request is held. A refused request is not retried until one of these two triggers occurs again.

Top module: `lprun_seq`

## Requirements
- R1: During and after reset, every control output is low, `lprun_o` and `err_o` are low, and `flash_ws_o` equals `run_ws_i`.
- R2: An entry attempt is refused unless three conditions hold: `clk_msi_i` is high, `sysclk_khz_i` is at most 4000, and every bit of `blk_en_i` is low (bit 0 USB, bit 1 CAN, bit 2 accelerator, bit 3 ADC). A refusal sets `err_o` the cycle after the attempt and changes no other output.
- R3: An entry attempt is made on the first cycle `lpr_req_i` is seen high after being low, or on any cycle `wake_lps_i` and `lpr_req_i` are both high. A request held high after a refusal makes no new attempt.
- R4: One cycle after an accepted attempt, `flash_ws_o` becomes the larger of `run_ws_i` and 2, and `pll_off_o` rises. One cycle later, `flash_lv_en_o` rises while the raised wait states are still in place.
- R5: The cycle after `flash_lv_ack_i` is sampled high, `flash_ws_o` becomes 0. The next cycle, `sram_lv_en_o`, `bg_on_o` and `mon_on_o` rise. The cycle after that, `mreg_off_o` rises.
- R6: `lprun_o` rises the cycle after `lpreg_rdy_i` is sampled high while `mreg_off_o` is high, and at no other time.
- R7: Dropping the request in low-power run clears `mreg_off_o` the next cycle. The cycle after `mreg_rdy_i` is sampled high, `lprun_o`, `sram_lv_en_o`, `bg_on_o`, `mon_on_o`, `flash_lv_en_o` and `pll_off_o` fall, and the wait states are raised to the larger of `run_ws_i` and 2. The cycle after `flash_lv_ack_i` is sampled low, the wait states return to `run_ws_i`.
- R8: A wait that sees no acknowledge for `tmo_lim_i`+1 sampled cycles sets `err_o` and unwinds. A flash timeout drops the flash low-voltage enable at once. A regulator timeout first turns the main regulator back on and waits for it before the SRAM and flash are restored. `lprun_o` stays low throughout.
- R9: Dropping the request before low-power run is reached unwinds the steps taken so far, without raising `err_o`.
- R10: `err_o` holds while the request stays high, and clears the cycle after the request is seen low in the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lpr_req_i | input | 1 | Low-power run request level |
| wake_lps_i | input | 1 | Wake from low-power sleep pulse |
| clk_msi_i | input | 1 | System clock taken from the multi-speed internal oscillator |
| sysclk_khz_i | input | KHZW | Current system clock frequency in kHz |
| blk_en_i | input | NBLK | Enables of blocks barred from low-power run |
| run_ws_i | input | WSW | Flash wait states used in normal run |
| tmo_lim_i | input | TW | Acknowledge timeout limit in cycles |
| flash_lv_ack_i | input | 1 | Flash reports low-voltage mode |
| lpreg_rdy_i | input | 1 | Low-power regulator carries the core |
| mreg_rdy_i | input | 1 | Main regulator ready |
| flash_ws_o | output | WSW | Flash read wait states |
| flash_lv_en_o | output | 1 | Flash low-voltage enable |
| sram_lv_en_o | output | 1 | SRAM low-voltage enable |
| mreg_off_o | output | 1 | Main regulator disable |
| pll_off_o | output | 1 | PLL disable |
| bg_on_o | output | 1 | Bandgap forced on |
| mon_on_o | output | 1 | Voltage and brown-out monitors forced on |
| lprun_o | output | 1 | Low-power run status |
| err_o | output | 1 | Last attempt refused or timed out |

## Verification
The state register drives every output, so each step appears exactly one cycle after the edge that samples its cause. A refusal, a launch, a flash-ready sample, a regulator-ready sample and a timeout each take effect one cycle later. A timeout occurs at the (`tmo_lim_i`+1)th sampled cycle of a wait. The bench models the flash and both regulators as two-flop acknowledge delays, so a control change is acknowledged in the third cycle after it. Every expected output change is queued with the absolute cycle in which it is due. The monitor samples shortly after each rising edge, and any output change that is not queued, or that arrives in the wrong cycle or with the wrong value, counts as a failure.

// File: rtl/lprun_pkg.sv
package lprun_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RAISE,
    ST_FLV,
    ST_WSZ,
    ST_SRAM,
    ST_HAND,
    ST_LPRUN,
    ST_MRON,
    ST_FLOFF
  } seq_st_e;

  function automatic logic st_waits(seq_st_e s);
    return (s == ST_FLV) || (s == ST_HAND) || (s == ST_MRON) || (s == ST_FLOFF);
  endfunction

endpackage

// File: rtl/lprun_rstsync.sv
module lprun_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_int_n = sync_q[1];
endmodule

// File: rtl/lprun_gate.sv
module lprun_gate #(
  parameter int KHZW    = 16,
  parameter int MAX_KHZ = 4000,
  parameter int NBLK    = 4
) (
  input  logic            src_msi_i,
  input  logic [KHZW-1:0] khz_i,
  input  logic [NBLK-1:0] blk_en_i,
  output logic            ok_o
);
  localparam logic [KHZW-1:0] KHZ_CAP = KHZW'(MAX_KHZ);

  logic any_blk;
  assign any_blk = |blk_en_i;
  assign ok_o    = src_msi_i & (khz_i <= KHZ_CAP) & ~any_blk;
endmodule

// File: rtl/lprun_timer.sv
module lprun_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          clr_i,
  input  logic [TW-1:0] lim_i,
  output logic          expired_o
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr_i || !run_i) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (cnt_q != lim_i) begin
      cnt_d  = cnt_q + TW'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = run_i & (cnt_q == lim_i);
endmodule

// File: rtl/lprun_fsm.sv
module lprun_fsm
  import lprun_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_i,
  input  logic    wake_i,
  input  logic    gate_ok_i,
  input  logic    flash_ack_i,
  input  logic    lp_rdy_i,
  input  logic    mr_rdy_i,
  input  logic    expired_i,
  output seq_st_e state_o,
  output logic    moved_o,
  output logic    err_o,
  output logic    lprun_o
);
  seq_st_e st_q, st_d;
  logic    req_q;
  logic    err_q, err_d;
  logic    lp_q, lp_d;
  logic    launch;

  assign launch = req_i & (~req_q | wake_i);

  always_comb begin
    st_d  = st_q;
    err_d = err_q;
    lp_d  = lp_q;
    unique case (st_q)
      ST_IDLE: begin
        if (!req_i) begin
          err_d = 1'b0;
        end else if (launch) begin
          if (gate_ok_i) begin
            st_d  = ST_RAISE;
            err_d = 1'b0;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_RAISE: st_d = req_i ? ST_FLV : ST_IDLE;
      ST_FLV: begin
        if (!req_i)          st_d = ST_FLOFF;
        else if (flash_ack_i) st_d = ST_WSZ;
        else if (expired_i) begin
          st_d  = ST_FLOFF;
          err_d = 1'b1;
        end
      end
      ST_WSZ:  st_d = req_i ? ST_SRAM : ST_FLOFF;
      ST_SRAM: st_d = req_i ? ST_HAND : ST_FLOFF;
      ST_HAND: begin
        if (!req_i) st_d = ST_MRON;
        else if (lp_rdy_i) begin
          st_d = ST_LPRUN;
          lp_d = 1'b1;
        end else if (expired_i) begin
          st_d  = ST_MRON;
          err_d = 1'b1;
        end
      end
      ST_LPRUN: if (!req_i) st_d = ST_MRON;
      ST_MRON: begin
        if (mr_rdy_i) begin
          st_d = ST_FLOFF;
          lp_d = 1'b0;
        end else if (expired_i) begin
          st_d  = ST_FLOFF;
          lp_d  = 1'b0;
          err_d = 1'b1;
        end
      end
      ST_FLOFF: begin
        if (!flash_ack_i) st_d = ST_IDLE;
        else if (expired_i) begin
          st_d  = ST_IDLE;
          err_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      req_q <= 1'b0;
      err_q <= 1'b0;
      lp_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      req_q <= req_i;
      err_q <= err_d;
      lp_q  <= lp_d;
    end
  end

  assign state_o = st_q;
  assign moved_o = (st_d != st_q);
  assign err_o   = err_q;
  assign lprun_o = lp_q;
endmodule

// File: rtl/lprun_outdec.sv
module lprun_outdec
  import lprun_pkg::*;
#(
  parameter int WSW    = 3,
  parameter int MIN_WS = 2
) (
  input  seq_st_e        state_i,
  input  logic [WSW-1:0] run_ws_i,
  output logic [WSW-1:0] ws_o,
  output logic           flash_lv_o,
  output logic           sram_lv_o,
  output logic           aon_o,
  output logic           mreg_off_o,
  output logic           pll_off_o
);
  localparam logic [WSW-1:0] WS_FLOOR = WSW'(MIN_WS);

  logic [WSW-1:0] ws_raised;
  assign ws_raised = (run_ws_i >= WS_FLOOR) ? run_ws_i : WS_FLOOR;

  always_comb begin
    ws_o       = '0;
    flash_lv_o = 1'b0;
    sram_lv_o  = 1'b0;
    mreg_off_o = 1'b0;
    pll_off_o  = 1'b0;
    unique case (state_i)
      ST_IDLE:  ws_o = run_ws_i;
      ST_RAISE: begin
        ws_o      = ws_raised;
        pll_off_o = 1'b1;
      end
      ST_FLV: begin
        ws_o       = ws_raised;
        pll_off_o  = 1'b1;
        flash_lv_o = 1'b1;
      end
      ST_WSZ: begin
        pll_off_o  = 1'b1;
        flash_lv_o = 1'b1;
      end
      ST_SRAM, ST_MRON: begin
        pll_off_o  = 1'b1;
        flash_lv_o = 1'b1;
        sram_lv_o  = 1'b1;
      end
      ST_HAND, ST_LPRUN: begin
        pll_off_o  = 1'b1;
        flash_lv_o = 1'b1;
        sram_lv_o  = 1'b1;
        mreg_off_o = 1'b1;
      end
      ST_FLOFF: ws_o = ws_raised;
      default:  ws_o = run_ws_i;
    endcase
  end

  assign aon_o = sram_lv_o;
endmodule

// File: rtl/lprun_seq.sv
module lprun_seq
  import lprun_pkg::*;
#(
  parameter int KHZW    = 16,
  parameter int MAX_KHZ = 4000,
  parameter int NBLK    = 4,
  parameter int WSW     = 3,
  parameter int MIN_WS  = 2,
  parameter int TW      = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lpr_req_i,
  input  logic            wake_lps_i,
  input  logic            clk_msi_i,
  input  logic [KHZW-1:0] sysclk_khz_i,
  input  logic [NBLK-1:0] blk_en_i,
  input  logic [WSW-1:0]  run_ws_i,
  input  logic [TW-1:0]   tmo_lim_i,
  input  logic            flash_lv_ack_i,
  input  logic            lpreg_rdy_i,
  input  logic            mreg_rdy_i,
  output logic [WSW-1:0]  flash_ws_o,
  output logic            flash_lv_en_o,
  output logic            sram_lv_en_o,
  output logic            mreg_off_o,
  output logic            pll_off_o,
  output logic            bg_on_o,
  output logic            mon_on_o,
  output logic            lprun_o,
  output logic            err_o
);
  logic    rst_int_n;
  logic    gate_ok;
  logic    expired;
  logic    moved;
  logic    aon;
  seq_st_e state;

  lprun_rstsync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  lprun_gate #(.KHZW(KHZW), .MAX_KHZ(MAX_KHZ), .NBLK(NBLK)) u_gate (
    .src_msi_i (clk_msi_i),
    .khz_i     (sysclk_khz_i),
    .blk_en_i  (blk_en_i),
    .ok_o      (gate_ok)
  );

  lprun_timer #(.TW(TW)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run_i     (st_waits(state)),
    .clr_i     (moved),
    .lim_i     (tmo_lim_i),
    .expired_o (expired)
  );

  lprun_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req_i       (lpr_req_i),
    .wake_i      (wake_lps_i),
    .gate_ok_i   (gate_ok),
    .flash_ack_i (flash_lv_ack_i),
    .lp_rdy_i    (lpreg_rdy_i),
    .mr_rdy_i    (mreg_rdy_i),
    .expired_i   (expired),
    .state_o     (state),
    .moved_o     (moved),
    .err_o       (err_o),
    .lprun_o     (lprun_o)
  );

  lprun_outdec #(.WSW(WSW), .MIN_WS(MIN_WS)) u_dec (
    .state_i    (state),
    .run_ws_i   (run_ws_i),
    .ws_o       (flash_ws_o),
    .flash_lv_o (flash_lv_en_o),
    .sram_lv_o  (sram_lv_en_o),
    .aon_o      (aon),
    .mreg_off_o (mreg_off_o),
    .pll_off_o  (pll_off_o)
  );

  assign bg_on_o  = aon;
  assign mon_on_o = aon;
endmodule

// File: rtl/lprun_seq_chk.sv
module lprun_seq_chk #(
  parameter int KHZW    = 16,
  parameter int MAX_KHZ = 4000,
  parameter int NBLK    = 4,
  parameter int WSW     = 3,
  parameter int MIN_WS  = 2
) (
  input logic            clk,
  input logic            rst_int_n,
  input logic            clk_msi_i,
  input logic [KHZW-1:0] sysclk_khz_i,
  input logic [NBLK-1:0] blk_en_i,
  input logic            flash_lv_ack_i,
  input logic            lpreg_rdy_i,
  input logic [WSW-1:0]  flash_ws_o,
  input logic            flash_lv_en_o,
  input logic            sram_lv_en_o,
  input logic            mreg_off_o,
  input logic            pll_off_o,
  input logic            bg_on_o,
  input logic            lprun_o
);
  localparam logic [KHZW-1:0] CAP   = KHZW'(MAX_KHZ);
  localparam logic [WSW-1:0]  FLOOR = WSW'(MIN_WS);

  assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(pll_off_o) |-> $past(clk_msi_i && (sysclk_khz_i <= CAP) && (blk_en_i == '0)));

  assert_ws_before_lv_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(flash_lv_en_o) |-> (flash_ws_o >= FLOOR));

  assert_ws_drop_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (flash_lv_en_o && $past(flash_lv_en_o) && flash_ws_o == '0 && $past(flash_ws_o) >= FLOOR)
      |-> $past(flash_lv_ack_i));

  assert_handover_order_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    mreg_off_o |-> (sram_lv_en_o && bg_on_o && flash_lv_en_o && flash_ws_o == '0));

  assert_status_rise_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(lprun_o) |-> $past(lpreg_rdy_i && mreg_off_o));

  assert_status_fall_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(lprun_o) |-> (!mreg_off_o && !sram_lv_en_o && !flash_lv_en_o));
endmodule

bind lprun_seq lprun_seq_chk #(
  .KHZW(KHZW), .MAX_KHZ(MAX_KHZ), .NBLK(NBLK), .WSW(WSW), .MIN_WS(MIN_WS)
) u_chk (
  .clk            (clk),
  .rst_int_n      (rst_int_n),
  .clk_msi_i      (clk_msi_i),
  .sysclk_khz_i   (sysclk_khz_i),
  .blk_en_i       (blk_en_i),
  .flash_lv_ack_i (flash_lv_ack_i),
  .lpreg_rdy_i    (lpreg_rdy_i),
  .flash_ws_o     (flash_ws_o),
  .flash_lv_en_o  (flash_lv_en_o),
  .sram_lv_en_o   (sram_lv_en_o),
  .mreg_off_o     (mreg_off_o),
  .pll_off_o      (pll_off_o),
  .bg_on_o        (bg_on_o),
  .lprun_o        (lprun_o)
);

// File: tb/test_lprun_seq.sv
`timescale 1ns/1ps
module test_lprun_seq;
  logic        clk;
  logic        rst_n;
  logic        req, wake, msi;
  logic [15:0] khz;
  logic [3:0]  blk;
  logic [2:0]  run_ws;
  logic [15:0] lim;
  logic        fl_ok, lp_ok;
  logic        f1, f2, l1, l2, m1, m2;
  logic [2:0]  ws;
  logic        flv, srlv, moff, poff, bg, mon, lpr, err;

  typedef struct {
    logic [10:0] v;
    int          cyc;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          cyc;
  int          checks;
  int          fails;
  logic [10:0] last;
  logic        mon_on;

  lprun_seq i_lprun_seq (
    .clk(clk), .rst_n(rst_n), .lpr_req_i(req), .wake_lps_i(wake),
    .clk_msi_i(msi), .sysclk_khz_i(khz), .blk_en_i(blk), .run_ws_i(run_ws),
    .tmo_lim_i(lim), .flash_lv_ack_i(f2), .lpreg_rdy_i(l2), .mreg_rdy_i(m2),
    .flash_ws_o(ws), .flash_lv_en_o(flv), .sram_lv_en_o(srlv), .mreg_off_o(moff),
    .pll_off_o(poff), .bg_on_o(bg), .mon_on_o(mon), .lprun_o(lpr), .err_o(err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // two-flop models of the flash and both regulators
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f1 <= 1'b0; f2 <= 1'b0; l1 <= 1'b0; l2 <= 1'b0; m1 <= 1'b1; m2 <= 1'b1;
    end else begin
      f1 <= flv & fl_ok;  f2 <= f1;
      l1 <= moff & lp_ok; l2 <= l1;
      m1 <= ~moff;        m2 <= m1;
    end
  end

  function automatic logic [10:0] bv(logic lp, logic mo, logic aon, logic sr,
                                     logic fl, logic pl, logic er, logic [2:0] w);
    return {lp, mo, aon, aon, sr, fl, pl, er, w};
  endfunction

  function automatic logic [10:0] obs();
    return {lpr, moff, bg, mon, srlv, flv, poff, err, ws};
  endfunction

  task automatic expect_at(int dc, logic [10:0] v, string tag);
    exp_t e;
    e.v = v; e.cyc = cyc + dc; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(string tag);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d expected changes missing, actual 0 expected %0d", tag, q.size(), q.size());
      q.delete();
    end
  endtask

  // scoreboard monitor: every output change must match the queued item due now
  always @(posedge clk) begin
    cyc++;
    #3;
    if (mon_on && obs() != last) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL unexpected change at cycle %0d: actual %b expected %b", cyc, obs(), last);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.v != obs() || e.cyc != cyc) begin
          fails++;
          $display("FAIL %s cycle %0d: actual %b expected %b due cycle %0d",
                   e.tag, cyc, obs(), e.v, e.cyc);
        end
      end
      last = obs();
    end
  end

  task automatic entry_ok(logic [2:0] rw, logic via_wake);
    if (via_wake) begin
      wake = 1'b1;
    end else begin
      req = 1'b1;
    end
    expect_at(1,  bv(0,0,0,0,0,1,0,rw), "R4");
    expect_at(2,  bv(0,0,0,0,1,1,0,rw), "R4");
    expect_at(5,  bv(0,0,0,0,1,1,0,0),  "R5");
    expect_at(6,  bv(0,0,1,1,1,1,0,0),  "R5");
    expect_at(7,  bv(0,1,1,1,1,1,0,0),  "R5");
    expect_at(10, bv(1,1,1,1,1,1,0,0),  "R6");
    step(1);
    wake = 1'b0;
    step(14);
    drain("R6");
  endtask

  initial begin
    checks = 0; fails = 0; cyc = 0; mon_on = 1'b0;
    rst_n = 1'b0; req = 1'b0; wake = 1'b0; msi = 1'b1; khz = 16'd4000;
    blk = 4'b0; run_ws = 3'd1; lim = 16'd100; fl_ok = 1'b1; lp_ok = 1'b1;
    step(3);
    rst_n = 1'b1;
    step(4);
    // R1: reset state
    checks++;
    if (obs() != bv(0,0,0,0,0,0,0,3'd1)) begin
      fails++;
      $display("FAIL R1: actual %b expected %b", obs(), bv(0,0,0,0,0,0,0,3'd1));
    end
    last = obs();
    mon_on = 1'b1;

    // full entry at the 4000 kHz boundary (R2, R4, R5, R6), then exit (R7)
    entry_ok(3'd2, 1'b0);
    req = 1'b0;
    expect_at(1, bv(1,0,1,1,1,1,0,0), "R7");
    expect_at(4, bv(0,0,0,0,0,0,0,2), "R7");
    expect_at(7, bv(0,0,0,0,0,0,0,1), "R7");
    step(12);
    drain("R7");

    // ADC enabled: refusal (R2); held request makes no new attempt (R3)
    blk = 4'b1000; req = 1'b1;
    expect_at(1, bv(0,0,0,0,0,0,1,1), "R2");
    step(8);
    drain("R3");
    blk = 4'b0; run_ws = 3'd3;
    expect_at(1, bv(0,0,0,0,0,0,1,3), "R1");
    step(4);
    drain("R3");
    // wake from low-power sleep launches with request held (R3), ws above floor (R4)
    entry_ok(3'd3, 1'b1);
    req = 1'b0;
    expect_at(1, bv(1,0,1,1,1,1,0,0), "R7");
    expect_at(4, bv(0,0,0,0,0,0,0,3), "R7");
    step(12);
    drain("R7");
    run_ws = 3'd1;
    expect_at(1, bv(0,0,0,0,0,0,0,1), "R1");
    step(3);

    // each remaining blocked enable refuses; error clears with request low (R2, R10)
    for (int i = 0; i < 3; i++) begin
      blk = 4'(1 << i); req = 1'b1;
      expect_at(1, bv(0,0,0,0,0,0,1,1), "R2");
      step(4);
      req = 1'b0;
      expect_at(1, bv(0,0,0,0,0,0,0,1), "R10");
      step(3);
    end
    blk = 4'b0;
    drain("R2");

    // frequency one above the limit, then non-oscillator source (R2, R10)
    khz = 16'd4001; req = 1'b1;
    expect_at(1, bv(0,0,0,0,0,0,1,1), "R2");
    step(4);
    req = 1'b0;
    expect_at(1, bv(0,0,0,0,0,0,0,1), "R10");
    step(3);
    khz = 16'd4000; msi = 1'b0; req = 1'b1;
    expect_at(1, bv(0,0,0,0,0,0,1,1), "R2");
    step(4);
    req = 1'b0;
    expect_at(1, bv(0,0,0,0,0,0,0,1), "R10");
    step(3);
    msi = 1'b1;
    drain("R2");

    // flash never acknowledges (R8)
    fl_ok = 1'b0; lim = 16'd5; req = 1'b1;
    expect_at(1, bv(0,0,0,0,0,1,0,2), "R4");
    expect_at(2, bv(0,0,0,0,1,1,0,2), "R4");
    expect_at(8, bv(0,0,0,0,0,0,1,2), "R8");
    expect_at(9, bv(0,0,0,0,0,0,1,1), "R8");
    step(14);
    drain("R8");
    req = 1'b0;
    expect_at(1, bv(0,0,0,0,0,0,0,1), "R10");
    step(3);
    fl_ok = 1'b1;

    // low-power regulator never takes over (R8)
    lp_ok = 1'b0; req = 1'b1;
    expect_at(1,  bv(0,0,0,0,0,1,0,2), "R4");
    expect_at(2,  bv(0,0,0,0,1,1,0,2), "R4");
    expect_at(5,  bv(0,0,0,0,1,1,0,0), "R5");
    expect_at(6,  bv(0,0,1,1,1,1,0,0), "R5");
    expect_at(7,  bv(0,1,1,1,1,1,0,0), "R5");
    expect_at(13, bv(0,0,1,1,1,1,1,0), "R8");
    expect_at(16, bv(0,0,0,0,0,0,1,2), "R8");
    expect_at(19, bv(0,0,0,0,0,0,1,1), "R8");
    step(24);
    drain("R8");
    req = 1'b0;
    expect_at(1, bv(0,0,0,0,0,0,0,1), "R10");
    step(3);
    lp_ok = 1'b1; lim = 16'd100;

    // request dropped while waiting on the flash (R9)
    req = 1'b1;
    expect_at(1, bv(0,0,0,0,0,1,0,2), "R4");
    expect_at(2, bv(0,0,0,0,1,1,0,2), "R4");
    step(2);
    req = 1'b0;
    expect_at(1, bv(0,0,0,0,0,0,0,2), "R9");
    expect_at(2, bv(0,0,0,0,0,0,0,1), "R9");
    step(10);
    drain("R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule